// File: doc/BRIEF.md
# Table-Driven GFSK Baseband Modulator

This block converts a serial stream of raw bits into a continuous complex baseband GFSK waveform that can drive a pair of DAC channels directly. Each accepted bit becomes an antipodal symbol (+1 or -1), and each symbol period is rendered as `SPS` output samples. The Gaussian pulse-shaping filter is not built as multiply-accumulate logic. A precomputed frequency table takes its place. The table is addressed by the history of the last `HIST_LEN` symbols and by the sample position inside the current symbol.

The table output is an instantaneous frequency word. A phase accumulator acts as the oscillator and adds that word to its phase on every sample. The phase therefore never jumps, and a change in the shaped frequency shows up as a change in the rate of rotation. The upper phase bits address a quarter-wave sine table, which is folded by quadrant to give signed cosine (I) and sine (Q) samples.

Upstream logic offers bits through a valid/ready pair. The block takes exactly one bit per symbol period and never stalls its output. If no bit is offered when one is due, a -1 symbol is inserted in its place.

Top module: `gfsk_modulator`

## Requirements
- R1: While `rst` is high (synchronous, active high), the block clears its state: every history slot holds the -1 symbol, the phase is zero, the sample index is zero, and `out_valid`, `out_i` and `out_q` are 0. The first sample after reset is therefore the point at phase zero: I = 2046, Q = 6.
- R2: `bit_ready` is high only in the last sample of each symbol (sample index `SPS`-1). With the default `SPS` = 20, it is first high in the 20th cycle after reset and then once every 20 cycles.
- R3: When `bit_ready` is high, the history shifts by one symbol. A new symbol enters: `bit_data` = 1 gives +1 and `bit_data` = 0 gives -1. If `bit_valid` is low at that point, a -1 symbol is inserted.
- R4: The frequency word for history h (bit k is the symbol k periods old, 1 = +1) and sample index n is F = trunc((sum over k of s_k * w(k*SPS+n)) * 32 / 5), truncated toward zero. Here the tap weight is w(t) = t+1 for t < HIST_LEN*SPS/2 and HIST_LEN*SPS - t otherwise.
- R5: Every sample, the 16-bit phase advances by the sign-extended frequency word, modulo 2^16. The phase step never exceeds the steady-state peak deviation, which is 524 counts (a modulation index of 0.32 at 20 samples per symbol).
- R6: Each output sample is taken from the phase held before the clock edge, so the output lags the phase by one cycle. The top 10 phase bits select the angle. The quarter-wave value for index r (0..255) is T(r) = trunc(2047*4*x / (1310720 - x)), where x = (2r+1)*(1024-(2r+1)). Q = sin and I = cos, folded by quadrant from T.
- R7: A run of identical symbols lasting at least `HIST_LEN` symbols produces a constant frequency of +524 or -524 counts per sample, and the I/Q point rotates at that rate across all four quadrants and through phase wraparound.
- R8: `out_valid` is 0 during reset, rises at the first clock edge after reset and stays high for as long as reset stays low.
- R9: `bit_valid` and `bit_data` have no effect on the output while `bit_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one output sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | A raw bit is offered |
| bit_data | input | 1 | Raw bit value (1 gives +1, 0 gives -1) |
| bit_ready | output | 1 | The block takes a bit in this cycle |
| out_valid | output | 1 | `out_i`/`out_q` carry a sample |
| out_i | output | OUT_W (12) | Signed cosine sample |
| out_q | output | OUT_W (12) | Signed sine sample |

## Verification
The bench builds the block with its default parameters: 20 samples per symbol, a 4-symbol history, a 16-bit phase and a 10-bit angle. At these values a run of equal symbols wraps the phase roughly every 125 samples. A few symbols of constant input therefore sweep every quadrant of the folded sine table and cross the wrap point in both directions. The 4-symbol history is short enough that patterns such as alternating bits, pairs and inserted fill symbols visit many table rows within a few hundred cycles, and every sample is compared against an independent model.

// File: rtl/gfsk_pkg.sv
package gfsk_pkg;

    // Tap weight of the triangular-Gaussian pulse at sample age t.
    function automatic int pulse_tap(input int t, input int sps, input int hlen);
        int span;
        span = hlen * sps;
        if (t < span / 2)
            return t + 1;
        return span - t;
    endfunction

    // Shaped frequency word for a symbol history and a sample index.
    function automatic int freq_entry(input int hist, input int n, input int sps,
                                      input int hlen, input int num, input int den);
        int acc;
        acc = 0;
        for (int k = 0; k < hlen; k++) begin
            if (((hist >> k) & 1) == 1)
                acc += pulse_tap(k * sps + n, sps, hlen);
            else
                acc -= pulse_tap(k * sps + n, sps, hlen);
        end
        return (acc * num) / den;
    endfunction

    // Quarter-wave sine value for index a, sampled at the bin centre.
    function automatic int quarter_sine(input int a, input int qlen, input int amp);
        longint p, h, x;
        p = longint'(2 * a + 1);
        h = longint'(4 * qlen);
        x = p * (h - p);
        return int'((longint'(amp) * 4 * x) / ((5 * h * h) / 4 - x));
    endfunction

endpackage

// File: rtl/gfsk_freq_table.sv
module gfsk_freq_table #(
    parameter int SPS      = 20,
    parameter int HIST_LEN = 4,
    parameter int FREQ_W   = 12,
    parameter int FREQ_NUM = 32,
    parameter int FREQ_DEN = 5
) (
    input  logic [HIST_LEN-1:0]        hist,
    input  logic [$clog2(SPS)-1:0]     idx,
    output logic signed [FREQ_W-1:0]   freq
);
    localparam int IDX_W  = $clog2(SPS);
    localparam int ADDR_W = HIST_LEN + IDX_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PEAK   = gfsk_pkg::freq_entry((1 << HIST_LEN) - 1, 0, SPS,
                                                 HIST_LEN, FREQ_NUM, FREQ_DEN);

    logic signed [FREQ_W-1:0] rom [DEPTH];

    // Entries beyond the last sample index are never addressed; they hold zero.
    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam int HV  = g >> IDX_W;
        localparam int NV  = g & ((1 << IDX_W) - 1);
        localparam int VAL = (NV < SPS)
                           ? gfsk_pkg::freq_entry(HV, NV, SPS, HIST_LEN, FREQ_NUM, FREQ_DEN)
                           : 0;
        assign rom[g] = FREQ_W'(VAL);
    end

    assign freq = rom[{hist, idx}];

    always_comb begin
        assert_freq_bound_R4: assert (int'(freq) <= PEAK && int'(freq) >= -PEAK)
            else $error("frequency word outside peak deviation");
    end

endmodule

// File: rtl/gfsk_sincos.sv
module gfsk_sincos #(
    parameter int TRIG_BITS = 10,
    parameter int OUT_W     = 12
) (
    input  logic [TRIG_BITS-1:0]      angle,
    output logic signed [OUT_W-1:0]   cos_o,
    output logic signed [OUT_W-1:0]   sin_o
);
    localparam int QA_W = TRIG_BITS - 2;
    localparam int QLEN = 1 << QA_W;
    localparam int AMP  = (1 << (OUT_W - 1)) - 1;

    logic signed [OUT_W-1:0] quarter [QLEN];

    for (genvar g = 0; g < QLEN; g++) begin : g_quarter
        localparam int VAL = gfsk_pkg::quarter_sine(g, QLEN, AMP);
        assign quarter[g] = OUT_W'(VAL);
    end

    logic [1:0]              quad;
    logic [QA_W-1:0]         ofs;
    logic signed [OUT_W-1:0] near_v, far_v;

    assign quad   = angle[TRIG_BITS-1 -: 2];
    assign ofs    = angle[QA_W-1:0];
    assign near_v = quarter[ofs];
    assign far_v  = quarter[~ofs];

    always_comb begin
        case (quad)
            2'd0:    begin sin_o = near_v;  cos_o = far_v;   end
            2'd1:    begin sin_o = far_v;   cos_o = -near_v; end
            2'd2:    begin sin_o = -near_v; cos_o = -far_v;  end
            default: begin sin_o = -far_v;  cos_o = near_v;  end
        endcase
    end

    // The folded point must lie near the unit circle: |c|+|s| spans [AMP, 1.5*AMP].
    always_comb begin
        automatic int ac = (cos_o < 0) ? -int'(cos_o) : int'(cos_o);
        automatic int as = (sin_o < 0) ? -int'(sin_o) : int'(sin_o);
        assert_trig_radius_R6: assert (ac + as >= AMP - AMP / 32 && ac + as <= AMP + AMP / 2)
            else $error("sin/cos point off the circle");
    end

endmodule

// File: rtl/gfsk_modulator.sv
module gfsk_modulator #(
    parameter int SPS       = 20,
    parameter int HIST_LEN  = 4,
    parameter int FREQ_W    = 12,
    parameter int PHASE_W   = 16,
    parameter int TRIG_BITS = 10,
    parameter int OUT_W     = 12,
    parameter int FREQ_NUM  = 32,
    parameter int FREQ_DEN  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             bit_data,
    output logic             bit_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_i,
    output logic [OUT_W-1:0] out_q
);
    localparam int IDX_W = $clog2(SPS);
    localparam int PEAK  = gfsk_pkg::freq_entry((1 << HIST_LEN) - 1, 0, SPS,
                                                HIST_LEN, FREQ_NUM, FREQ_DEN);
    localparam logic [IDX_W-1:0]           LAST_IDX = IDX_W'(SPS - 1);
    localparam logic signed [PHASE_W-1:0]  STEP_LIM = PHASE_W'(PEAK);

    typedef struct packed {
        logic [HIST_LEN-1:0]     hist;
        logic [IDX_W-1:0]        idx;
        logic [PHASE_W-1:0]      phase;
        logic signed [OUT_W-1:0] oi;
        logic signed [OUT_W-1:0] oq;
        logic                    ov;
    } state_t;

    state_t st_d, st_q;

    logic signed [FREQ_W-1:0] freq_w;
    logic signed [OUT_W-1:0]  cos_w, sin_w;
    logic                     take_w;

    gfsk_freq_table #(
        .SPS(SPS), .HIST_LEN(HIST_LEN), .FREQ_W(FREQ_W),
        .FREQ_NUM(FREQ_NUM), .FREQ_DEN(FREQ_DEN)
    ) u_table (
        .hist (st_q.hist),
        .idx  (st_q.idx),
        .freq (freq_w)
    );

    gfsk_sincos #(
        .TRIG_BITS(TRIG_BITS), .OUT_W(OUT_W)
    ) u_trig (
        .angle (st_q.phase[PHASE_W-1 -: TRIG_BITS]),
        .cos_o (cos_w),
        .sin_o (sin_w)
    );

    assign take_w = (st_q.idx == LAST_IDX);

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + {{(PHASE_W-FREQ_W){freq_w[FREQ_W-1]}}, freq_w};
        st_d.idx   = take_w ? '0 : st_q.idx + 1'b1;
        if (take_w)
            st_d.hist = {st_q.hist[HIST_LEN-2:0], bit_valid & bit_data};
        st_d.oi    = cos_w;
        st_d.oq    = sin_w;
        st_d.ov    = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bit_ready = take_w;
    assign out_valid = st_q.ov;
    assign out_i     = st_q.oi;
    assign out_q     = st_q.oq;

    assert_ready_single_R2: assert property (@(posedge clk) disable iff (rst)
        bit_ready |=> !bit_ready)
        else $error("ready held for more than one sample");

    assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.idx <= LAST_IDX)
        else $error("sample index out of range");

    assert_hist_shift_R3: assert property (@(posedge clk) disable iff (rst)
        bit_ready |=> st_q.hist[0] == ($past(bit_valid) & $past(bit_data)))
        else $error("accepted symbol not shifted in");

    assert_hist_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !bit_ready |=> $stable(st_q.hist))
        else $error("history changed between symbols");

    assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(st_q.phase - $past(st_q.phase)) <= STEP_LIM &&
                       $signed(st_q.phase - $past(st_q.phase)) >= -STEP_LIM))
        else $error("phase step exceeds peak deviation");

    assert_valid_hold_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid)
        else $error("out_valid dropped");

endmodule

// File: tb/tb_gfsk_modulator.sv
module tb_gfsk_modulator;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0;
    logic        bit_data = 1'b0;
    logic        bit_ready;
    logic        out_valid;
    logic [11:0] out_i, out_q;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit armed = 1'b0;
    bit first_seen = 1'b0;
    string tag = "R6";

    int    exp_i_q [$];
    int    exp_q_q [$];
    string exp_t_q [$];

    logic [3:0]  m_hist = '0;
    int          m_idx = 0;
    logic [15:0] m_phase = '0;

    always #10 clk = ~clk;

    gfsk_modulator dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data),
        .bit_ready(bit_ready), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    function automatic int ref_freq(logic [3:0] h, int n);
        int acc = 0;
        for (int age = 0; age < 4; age++) begin
            int t = age * 20 + n;
            int w = (t < 40) ? t + 1 : 80 - t;
            acc += h[age] ? w : -w;
        end
        return (acc * 32) / 5;
    endfunction

    function automatic int ref_quarter(int r);
        longint p = longint'(2 * r + 1);
        longint x = p * (1024 - p);
        return int'((2047 * 4 * x) / (1310720 - x));
    endfunction

    function automatic int ref_sin(int k);
        int m = k % 512;
        int r = (m < 256) ? m : 511 - m;
        return (k >= 512) ? -ref_quarter(r) : ref_quarter(r);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver: called at a falling edge, predicts the sample of the next rising edge.
    task automatic step(bit v, bit d);
        int  k;
        bit  rdy;
        bit_valid = v;
        bit_data  = d;
        rdy = (m_idx == 19);
        check(bit_ready == rdy, "R2 bit_ready", int'(bit_ready), int'(rdy));
        k = int'(m_phase[15:6]);
        exp_i_q.push_back(ref_sin((k + 256) % 1024));
        exp_q_q.push_back(ref_sin(k));
        exp_t_q.push_back(tag);
        m_phase = m_phase + 16'(ref_freq(m_hist, m_idx));
        if (rdy) m_hist = {m_hist[2:0], v & d};
        m_idx = rdy ? 0 : m_idx + 1;
        @(negedge clk);
        armed = 1'b1;
    endtask

    // One symbol period; the inputs outside the ready sample carry noise (R9).
    task automatic symbol(bit v, bit d);
        for (int s = 0; s < 20; s++) begin
            if (s == 19) step(v, d);
            else         step(1'b1, 1'(($urandom() >> 3) & 1));
        end
    endtask

    // Monitor: pops expected samples and compares after the driver has run.
    always @(negedge clk) begin
        #2;
        if (armed && !rst) begin
            int ei, eq;
            string et;
            check(out_valid == 1'b1, "R8 out_valid", int'(out_valid), 1);
            if (exp_i_q.size() > 0) begin
                ei = exp_i_q.pop_front();
                eq = exp_q_q.pop_front();
                et = exp_t_q.pop_front();
                if (!first_seen) begin
                    first_seen = 1'b1;
                    check($signed(out_i) == 2046, "R1 first I", int'($signed(out_i)), 2046);
                    check($signed(out_q) == 6, "R1 first Q", int'($signed(out_q)), 6);
                end
                check(int'($signed(out_i)) == ei, {et, " R4/R5/R6 I"}, int'($signed(out_i)), ei);
                check(int'($signed(out_q)) == eq, {et, " R4/R5/R6 Q"}, int'($signed(out_q)), eq);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_i == '0, "R1 out_i in reset", int'(out_i), 0);
        check(out_q == '0, "R1 out_q in reset", int'(out_q), 0);
        check(bit_ready == 1'b0, "R1 ready in reset", int'(bit_ready), 0);
        rst = 1'b0;

        tag = "R7 ones";
        for (int n = 0; n < 8; n++) symbol(1'b1, 1'b1);
        tag = "R7 zeros";
        for (int n = 0; n < 8; n++) symbol(1'b1, 1'b0);
        tag = "R3 alternating";
        for (int n = 0; n < 8; n++) symbol(1'b1, 1'(n & 1));
        tag = "R3 pairs";
        for (int n = 0; n < 8; n++) symbol(1'b1, 1'((n >> 1) & 1));
        tag = "R3 fill";
        for (int n = 0; n < 6; n++) symbol(1'b1, 1'b1);
        for (int n = 0; n < 6; n++) symbol(1'b0, 1'b1);
        tag = "R9 random";
        for (int n = 0; n < 16; n++)
            symbol(1'((($urandom() >> 5) & 3) != 0), 1'(($urandom() >> 7) & 1));

        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        armed = 1'b0;
        check(exp_i_q.size() <= 1, "R6 drained", exp_i_q.size(), 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule